// File: doc/BRIEF.md
# Flag-Producing 16-bit ALU

This block is the combinational arithmetic and logic stage of a small 16-bit RISC datapath. It takes two operands, the carry from the current flag state, a 4-bit operation code and a flag-update enable. In the same cycle it returns the result, a new flag vector and a strobe that says whether the destination register is to be written. The register file and the flag register sit outside the block. The current flags come in on `flagsIn`, and the block passes through any flag that an operation does not touch.

The block has a strict flag rule. Zero and parity follow every result that is written to a register, and they also follow a compare. Carry, negative and overflow change only on arithmetic operations. Logic operations and moves leave those three bits as they were. The two compare forms, one with a register operand and one with a 4-bit signed immediate, update the flags and never write the destination.

Top module: `flag_alu`

## Requirements
- R1: The operation codes are: 0 add, 1 sub, 2 addc, 3 subc, 4 and, 5 or, 6 xor, 7 cmp, 8 neg, 9 not, 10 mov, 11 addi, 12 cmpi. For these operations the result is A+B, A-B, A+B+cin, A-B-cin, A&B, A|B, A^B, A-B, 0-A, ~B, B, A+imm and A-imm, all modulo 2^16.
- R2: addc adds `carryIn` and subc subtracts `carryIn`. All other operations ignore `carryIn`.
- R3: The flag vector is packed Z=bit0, C=bit1, N=bit2, V=bit3, P=bit4. When Z is updated it is 1 exactly when all 16 result bits are zero.
- R4: On an add-type operation (add, addc, addi), C is the carry out of bit 15. On a subtract-type operation (sub, subc, cmp, cmpi, neg), C is 1 exactly when an unsigned borrow occurs.
- R5: On an arithmetic operation, N equals result bit 15.
- R6: On an arithmetic operation, V is 1 exactly when the true signed result does not fit in 16 bits.
- R7: When P is updated it is 1 exactly when the result holds an odd number of ones.
- R8: and, or, xor, not and mov update Z and P and leave C, N and V equal to `flagsIn`.
- R9: cmp and cmpi drive `destWrite` low and update all five flags. All other defined operations drive `destWrite` high.
- R10: The immediate of addi and cmpi is `opB[3:0]`, sign-extended, so its range is -8 to 7. The upper bits of `opB` are ignored.
- R11: While `flagUpdEn` is low, `flagsOut` equals `flagsIn` for every operation.
- R12: Codes 13 to 15 drive `destWrite` low, drive `result` to zero and leave all flags equal to `flagsIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand; bits 3:0 form the immediate |
| carryIn | input | 1 | Carry used by addc and subc |
| opSel | input | 4 | Operation code |
| flagUpdEn | input | 1 | Allows the flags to change |
| flagsIn | input | 5 | Current flag state {P,V,N,C,Z} |
| result | output | 16 | Operation result |
| flagsOut | output | 5 | Next flag state {P,V,N,C,Z} |
| destWrite | output | 1 | Destination register is to be written |

## Verification
The block holds no state, so a wrong decode strobe or a wrong operand selection shows at the ports in the same cycle as the operation code that causes it. The fault appears as a wrong result, a flag that changed when it should have held, or a write strobe on a compare. A fault in the carry or overflow logic shows only on operands near a boundary: sums that cross 0xFFFF, differences that cross zero, and signed values near 0x7FFF and 0x8000. The stimulus aims at those operands. Flag-hold faults can be seen only when `flagsIn` differs from what the operation would compute. For that reason the held flags are driven to values the operation would never produce.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FLAG_W = 5;
  localparam int F_Z = 0;
  localparam int F_C = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_P = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_NEG  = 4'd8,
    OP_NOT  = 4'd9,
    OP_MOV  = 4'd10,
    OP_ADDI = 4'd11,
    OP_CMPI = 4'd12
  } aluOp_e;

  typedef enum logic [2:0] {
    RES_ARITH,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_NOT,
    RES_MOV,
    RES_ZERO
  } resSel_e;

  typedef struct packed {
    logic    arith;
    logic    sub;
    logic    useCarry;
    logic    useImm;
    logic    negA;
    logic    wrDest;
    logic    updZP;
    resSel_e sel;
  } ctrlStrobes_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0]   opSel,
  output ctrlStrobes_t ctrl
);
  always_comb begin
    ctrl = '{arith: 1'b0, sub: 1'b0, useCarry: 1'b0, useImm: 1'b0,
             negA: 1'b0, wrDest: 1'b0, updZP: 1'b0, sel: RES_ZERO};
    case (opSel)
      OP_ADD:  begin ctrl.arith = 1'b1; ctrl.wrDest = 1'b1; ctrl.sel = RES_ARITH; end
      OP_SUB:  begin ctrl.arith = 1'b1; ctrl.sub = 1'b1; ctrl.wrDest = 1'b1; ctrl.sel = RES_ARITH; end
      OP_ADDC: begin ctrl.arith = 1'b1; ctrl.useCarry = 1'b1; ctrl.wrDest = 1'b1; ctrl.sel = RES_ARITH; end
      OP_SUBC: begin
        ctrl.arith = 1'b1; ctrl.sub = 1'b1; ctrl.useCarry = 1'b1;
        ctrl.wrDest = 1'b1; ctrl.sel = RES_ARITH;
      end
      OP_AND:  begin ctrl.wrDest = 1'b1; ctrl.sel = RES_AND; end
      OP_OR:   begin ctrl.wrDest = 1'b1; ctrl.sel = RES_OR; end
      OP_XOR:  begin ctrl.wrDest = 1'b1; ctrl.sel = RES_XOR; end
      OP_CMP:  begin ctrl.arith = 1'b1; ctrl.sub = 1'b1; ctrl.sel = RES_ARITH; end
      OP_NEG:  begin
        ctrl.arith = 1'b1; ctrl.sub = 1'b1; ctrl.negA = 1'b1;
        ctrl.wrDest = 1'b1; ctrl.sel = RES_ARITH;
      end
      OP_NOT:  begin ctrl.wrDest = 1'b1; ctrl.sel = RES_NOT; end
      OP_MOV:  begin ctrl.wrDest = 1'b1; ctrl.sel = RES_MOV; end
      OP_ADDI: begin ctrl.arith = 1'b1; ctrl.useImm = 1'b1; ctrl.wrDest = 1'b1; ctrl.sel = RES_ARITH; end
      OP_CMPI: begin ctrl.arith = 1'b1; ctrl.sub = 1'b1; ctrl.useImm = 1'b1; ctrl.sel = RES_ARITH; end
      default: ;
    endcase
    ctrl.updZP = ctrl.wrDest | ctrl.arith;
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              flagUpdEn,
  input  logic [FLAG_W-1:0] flagsIn,
  input  ctrlStrobes_t      ctrl,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] xOp;
  logic [DATA_W-1:0] yOp;
  logic              cinUsed;
  logic [DATA_W:0]   extSum;
  logic              cNew;
  logic              nNew;
  logic              vNew;

  always_comb begin
    immExt  = {{(DATA_W-IMM_W){opB[IMM_W-1]}}, opB[IMM_W-1:0]};
    xOp     = ctrl.negA ? '0 : opA;
    yOp     = ctrl.useImm ? immExt : (ctrl.negA ? opA : opB);
    cinUsed = ctrl.useCarry & carryIn;
    if (ctrl.sub)
      extSum = {1'b0, xOp} - {1'b0, yOp} - {{DATA_W{1'b0}}, cinUsed};
    else
      extSum = {1'b0, xOp} + {1'b0, yOp} + {{DATA_W{1'b0}}, cinUsed};
  end

  always_comb begin
    case (ctrl.sel)
      RES_ARITH: result = extSum[DATA_W-1:0];
      RES_AND:   result = opA & opB;
      RES_OR:    result = opA | opB;
      RES_XOR:   result = opA ^ opB;
      RES_NOT:   result = ~opB;
      RES_MOV:   result = opB;
      default:   result = '0;
    endcase
  end

  // carry out for add, borrow for subtract; the overflow term holds for both
  assign cNew = extSum[DATA_W];
  assign nNew = extSum[MSB];
  assign vNew = xOp[MSB] ^ yOp[MSB] ^ nNew ^ cNew;

  always_comb begin
    flagsOut = flagsIn;
    if (flagUpdEn) begin
      if (ctrl.updZP) begin
        flagsOut[F_Z] = ~|result;
        flagsOut[F_P] = ^result;
      end
      if (ctrl.arith) begin
        flagsOut[F_C] = cNew;
        flagsOut[F_N] = nNew;
        flagsOut[F_V] = vNew;
      end
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [3:0]        opSel,
  input  logic              flagUpdEn,
  input  logic [4:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        flagsOut,
  output logic              destWrite
);
  ctrlStrobes_t ctrl;

  alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .flagUpdEn (flagUpdEn),
    .flagsIn   (flagsIn),
    .ctrl      (ctrl),
    .result    (result),
    .flagsOut  (flagsOut)
  );

  assign destWrite = ctrl.wrDest;
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int DATA_W = 16
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              carryIn,
  input logic [3:0]        opSel,
  input logic              flagUpdEn,
  input logic [4:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        flagsOut,
  input logic              destWrite
);
  logic isArith;
  logic isLogic;
  logic isCmp;
  logic spare;

  assign isArith = (opSel <= 4'd3) || (opSel == 4'd7) || (opSel == 4'd8)
                || (opSel == 4'd11) || (opSel == 4'd12);
  assign isLogic = (opSel >= 4'd4 && opSel <= 4'd6) || (opSel == 4'd9) || (opSel == 4'd10);
  assign isCmp   = (opSel == 4'd7) || (opSel == 4'd12);
  assign spare   = ^{opA, opB, carryIn};

  always_comb begin
    if (flagUpdEn && (isArith || isLogic))
      p_zero_tracks_result_r3: assert (flagsOut[0] == (result == '0) || spare === 1'bx);
    if (flagUpdEn && (isArith || isLogic))
      p_parity_odd_ones_r7: assert (flagsOut[4] == ^result);
    if (flagUpdEn && isArith)
      p_negative_msb_r5: assert (flagsOut[2] == result[DATA_W-1]);
    if (isLogic)
      p_logic_keeps_cnv_r8: assert (flagsOut[3:1] == flagsIn[3:1]);
    if (!flagUpdEn)
      p_flags_frozen_r11: assert (flagsOut == flagsIn);
    if (isCmp)
      p_no_write_on_cmp_r9: assert (!destWrite);
    if (opSel >= 4'd13)
      p_spare_code_inert_r12: assert (!destWrite && result == '0 && flagsOut == flagsIn);
  end
endmodule

bind flag_alu alu_checker #(.DATA_W(DATA_W)) u_chk (
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .opSel     (opSel),
  .flagUpdEn (flagUpdEn),
  .flagsIn   (flagsIn),
  .result    (result),
  .flagsOut  (flagsOut),
  .destWrite (destWrite)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [3:0]  opSel = 4'd15;
  logic        flagUpdEn = 1'b0;
  logic [4:0]  flagsIn = '0;
  logic [15:0] result;
  logic [4:0]  flagsOut;
  logic        destWrite;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic [4:0]  fl;
    logic        we;
    string       tag;
  } item_t;

  item_t sbq[$];

  always #5 clk = ~clk;

  flag_alu i_flag_alu (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opSel(opSel),
    .flagUpdEn(flagUpdEn), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut), .destWrite(destWrite)
  );

  // reference written from the requirement text, using integer arithmetic
  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic cin, input logic en, input logic [4:0] fin,
                       output logic [15:0] r, output logic [4:0] f, output logic w);
    int ua, ub, sa, sb, c, imm, ures, sres;
    bit arith, logicOp, isSub;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    imm = int'($signed(b[3:0]));
    c = 0; arith = 1; logicOp = 0; isSub = 0;
    ures = 0; sres = 0; r = '0; w = 1'b1;
    case (op)
      4'd0:  begin ures = ua + ub;       sres = sa + sb; end
      4'd1:  begin ures = ua - ub;       sres = sa - sb; isSub = 1; end
      4'd2:  begin c = int'(cin); ures = ua + ub + c; sres = sa + sb + c; end
      4'd3:  begin c = int'(cin); ures = ua - ub - c; sres = sa - sb - c; isSub = 1; end
      4'd7:  begin ures = ua - ub;       sres = sa - sb; isSub = 1; w = 1'b0; end
      4'd8:  begin ures = 0 - ua;        sres = 0 - sa;  isSub = 1; end
      4'd11: begin ures = ua + (imm & 16'hFFFF); sres = sa + imm; end
      4'd12: begin ures = ua - (imm & 16'hFFFF); sres = sa - imm; isSub = 1; w = 1'b0; end
      default: arith = 0;
    endcase
    if (arith) r = ures[15:0];
    else begin
      logicOp = 1;
      case (op)
        4'd4:  r = a & b;
        4'd5:  r = a | b;
        4'd6:  r = a ^ b;
        4'd9:  r = ~b;
        4'd10: r = b;
        default: begin logicOp = 0; w = 1'b0; r = '0; end
      endcase
    end
    f = fin;
    if (en && (arith || logicOp)) begin
      f[0] = (r == 16'h0);
      f[4] = ($countones(r) % 2) == 1;
    end
    if (en && arith) begin
      f[1] = isSub ? (ures < 0) : (ures > 65535);
      f[2] = r[15];
      f[3] = (sres > 32767) || (sres < -32768);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic cin, input logic en, input logic [4:0] fin, input string tag);
    item_t it;
    @(negedge clk);
    opSel = op; opA = a; opB = b; carryIn = cin; flagUpdEn = en; flagsIn = fin;
    model(op, a, b, cin, en, fin, it.res, it.fl, it.we);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops each expected item at the edge after it was driven
  always @(posedge clk) begin
    if (sbq.size() > 0) begin
      item_t e;
      e = sbq.pop_front();
      check(result === e.res, e.tag, "result", result, e.res);
      check(flagsOut === e.fl, e.tag, "flags", {11'b0, flagsOut}, {11'b0, e.fl});
      check(destWrite === e.we, e.tag, "write", {15'b0, destWrite}, {15'b0, e.we});
    end
  end

  initial begin
    // idle state: spare code with updates off
    #1;
    check(destWrite === 1'b0 && result === 16'h0, "R12", "idle", result, 16'h0);
    drive(4'd0, 16'h1234, 16'h1111, 1'b0, 1'b1, 5'b00000, "R1 add");
    drive(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 5'b00000, "R3 R4 add carry zero");
    drive(4'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b1, 5'b00000, "R6 R5 add overflow");
    drive(4'd0, 16'h8000, 16'h8000, 1'b1, 1'b1, 5'b00000, "R2 add ignores carryIn");
    drive(4'd1, 16'h0003, 16'h0005, 1'b0, 1'b1, 5'b00000, "R4 sub borrow");
    drive(4'd1, 16'h8000, 16'h0001, 1'b0, 1'b1, 5'b00000, "R6 sub overflow");
    drive(4'd2, 16'hFFFE, 16'h0001, 1'b1, 1'b1, 5'b00000, "R2 addc");
    drive(4'd3, 16'h0005, 16'h0005, 1'b1, 1'b1, 5'b00000, "R2 subc");
    drive(4'd3, 16'h0005, 16'h0004, 1'b1, 1'b1, 5'b11111, "R3 subc zero");
    drive(4'd4, 16'hF0F0, 16'h0FF0, 1'b0, 1'b1, 5'b01110, "R8 and");
    drive(4'd5, 16'h0000, 16'h0000, 1'b0, 1'b1, 5'b01010, "R8 or zero");
    drive(4'd6, 16'hAAAA, 16'h0001, 1'b0, 1'b1, 5'b00100, "R7 xor parity");
    drive(4'd9, 16'h0000, 16'h00FF, 1'b0, 1'b1, 5'b01110, "R8 not");
    drive(4'd10, 16'h0000, 16'h8001, 1'b0, 1'b1, 5'b00000, "R8 mov");
    drive(4'd7, 16'h0002, 16'h0007, 1'b0, 1'b1, 5'b00000, "R9 cmp");
    drive(4'd7, 16'h1234, 16'h1234, 1'b0, 1'b1, 5'b11110, "R9 cmp equal");
    drive(4'd12, 16'h0000, 16'hFFF8, 1'b0, 1'b1, 5'b00000, "R10 cmpi -8");
    drive(4'd11, 16'h0010, 16'h5557, 1'b0, 1'b1, 5'b00000, "R10 addi +7");
    drive(4'd11, 16'h0003, 16'h000F, 1'b0, 1'b1, 5'b00000, "R10 addi -1");
    drive(4'd8, 16'h0001, 16'h0000, 1'b0, 1'b1, 5'b00000, "R1 neg");
    drive(4'd8, 16'h8000, 16'h0000, 1'b0, 1'b1, 5'b00000, "R6 neg min");
    drive(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 5'b10110, "R11 frozen add");
    drive(4'd7, 16'h0001, 16'h0002, 1'b0, 1'b0, 5'b01001, "R11 frozen cmp");
    drive(4'd13, 16'h1234, 16'h5678, 1'b1, 1'b1, 5'b10101, "R12 code13");
    drive(4'd15, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 5'b01010, "R12 code15");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule